// File: doc/BRIEF.md
# Harvard-bus memory space selector

This block produces the active-low chip selects for a microcontroller bus that keeps program fetches and data accesses apart. Program fetches use the PSEN strobe, and data reads and writes use RD and WR. An external decoder reports which EPROM block, the SRAM or the I/O window the current address falls in. This block combines those hit signals with the strobes and with a small control register. The register decides whether the program and data spaces stay separate or are merged into one shared space.

Each EPROM block also carries a placement flag. A block with the flag set lives in data space and answers only to RD. A block with the flag clear lives in program space. This lets software mix code and table data across the EPROM blocks. The register is written through a simple synchronous port, and its readback shows only the bits that are implemented.

Top module: `memspace_sel`

## Requirements
- R1: After reset the configuration readback is 0x00. In this state the spaces are separate: PSEN reaches only EPROM, and RD reaches only SRAM and I/O.
- R2: On a rising clock edge with cfg_cs and cfg_we both high, bits 7, 1 and 0 of cfg_wdata are stored. Bit 1 is the RD-to-EPROM enable and bit 0 is the PSEN-to-SRAM/IO enable. Bits 6 to 2 are discarded and always read back as 0.
- R3: An edge where cfg_cs or cfg_we is low leaves the readback unchanged.
- R4: A program-space EPROM block (flag 0) is selected (its select is low) when its hit is high and psen_n is low.
- R5: A program-space EPROM block is selected by rd_n low only when readback bit 1 is 1. With bit 1 at 0, RD low leaves it deselected.
- R6: A data-space EPROM block (flag 1) is selected when its hit is high and rd_n is low. PSEN never selects it.
- R7: The SRAM and I/O selects go low when their hit is high and either rd_n or wr_n is low, whatever the configuration.
- R8: psen_n low selects the SRAM and I/O only when readback bit 0 is 1.
- R9: wr_n low never selects any EPROM block.
- R10: A select stays high while its hit is low. When psen_n, rd_n and wr_n are all high, every select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| psen_n | input | 1 | Active-low program fetch strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| eprom_hit | input | NB | Address-range hit for each EPROM block |
| eprom_in_data | input | NB | Per-block flag, 1 places the block in data space |
| sram_hit | input | 1 | Address-range hit for the SRAM |
| io_hit | input | 1 | Address-range hit for the I/O window |
| cfg_cs | input | 1 | Configuration register select |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| eprom_sel_n | output | NB | Active-low EPROM block selects |
| sram_sel_n | output | 1 | Active-low SRAM select |
| io_sel_n | output | 1 | Active-low I/O select |

## Verification
The hardest situation to reach is the one where several rules act on one access at once. For example, RD is low on a bank that mixes data-space and program-space blocks while the RD-to-EPROM enable is set, or PSEN and WR are low together. The bench writes each of the four enable combinations into the register in turn. Under each one it sweeps all eight strobe combinations against sixteen patterns of hits and placement flags, and compares every select with an expectation built from the rules.

// File: rtl/memspace_sel.sv
module memspace_sel #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psen_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [NB-1:0] eprom_hit,
  input  logic [NB-1:0] eprom_in_data,
  input  logic          sram_hit,
  input  logic          io_hit,
  input  logic          cfg_cs,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  output logic [NB-1:0] eprom_sel_n,
  output logic          sram_sel_n,
  output logic          io_sel_n
);

  logic pio_q, rd_eprom_q, psen_dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pio_q      <= 1'b0;
      rd_eprom_q <= 1'b0;
      psen_dat_q <= 1'b0;
    end else if (cfg_cs && cfg_we) begin
      pio_q      <= cfg_wdata[7];
      rd_eprom_q <= cfg_wdata[1];
      psen_dat_q <= cfg_wdata[0];
    end
  end

  assign cfg_rdata = {pio_q, 5'b0, rd_eprom_q, psen_dat_q};

  logic psen, rd, wr;
  assign psen = ~psen_n;
  assign rd   = ~rd_n;
  assign wr   = ~wr_n;

  logic prog_strobe, data_strobe;
  assign prog_strobe = psen | (rd_eprom_q & rd);
  assign data_strobe = rd | wr | (psen_dat_q & psen);

  for (genvar i = 0; i < NB; i++) begin : g_blk
    assign eprom_sel_n[i] = ~(eprom_hit[i] & (eprom_in_data[i] ? rd : prog_strobe));
  end

  assign sram_sel_n = ~(sram_hit & data_strobe);
  assign io_sel_n   = ~(io_hit & data_strobe);

endmodule

module memspace_sel_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [NB-1:0] eprom_hit,
  input logic [NB-1:0] eprom_in_data,
  input logic          sram_hit,
  input logic          io_hit,
  input logic          cfg_cs,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic [NB-1:0] eprom_sel_n,
  input logic          sram_sel_n,
  input logic          io_sel_n
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:2] == 5'b0); // R2
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cs && cfg_we) |=> cfg_rdata == ($past(cfg_wdata) & 8'h83)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_cs && cfg_we) |=> $stable(cfg_rdata)); // R3
  AST_DATA_BLK_RD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> ((~eprom_sel_n & eprom_in_data) == '0)); // R6
  AST_NO_WR_EPROM: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && rd_n) |-> (&eprom_sel_n)); // R9
  AST_PROG_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && !cfg_rdata[1]) |-> ((~eprom_sel_n & ~eprom_in_data) == '0)); // R5
  AST_PSEN_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n && !cfg_rdata[0]) |-> (sram_sel_n && io_sel_n)); // R8
  AST_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (sram_sel_n == !sram_hit && io_sel_n == !io_hit)); // R7
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && rd_n && wr_n) |-> (&eprom_sel_n && sram_sel_n && io_sel_n)); // R10
  AST_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((~eprom_sel_n & ~eprom_hit) == '0) && (sram_hit || sram_sel_n) && (io_hit || io_sel_n)); // R10

endmodule

bind memspace_sel memspace_sel_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .eprom_hit(eprom_hit), .eprom_in_data(eprom_in_data),
  .sram_hit(sram_hit), .io_hit(io_hit),
  .cfg_cs(cfg_cs), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .eprom_sel_n(eprom_sel_n), .sram_sel_n(sram_sel_n), .io_sel_n(io_sel_n)
);

// File: tb/memspace_sel_tb.sv
module memspace_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [NB-1:0] eprom_hit = '0, eprom_in_data = '0;
  logic sram_hit = 1'b0, io_hit = 1'b0;
  logic cfg_cs = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [NB-1:0] eprom_sel_n;
  logic sram_sel_n, io_sel_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memspace_sel #(.NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .eprom_hit(eprom_hit), .eprom_in_data(eprom_in_data),
    .sram_hit(sram_hit), .io_hit(io_hit),
    .cfg_cs(cfg_cs), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .eprom_sel_n(eprom_sel_n), .sram_sel_n(sram_sel_n), .io_sel_n(io_sel_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic cs, input logic we, input logic [7:0] d);
    @(negedge clk);
    cfg_cs = cs; cfg_we = we; cfg_wdata = d;
    @(negedge clk);
    cfg_cs = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  function automatic logic [NB+1:0] expect_sel(input logic [7:0] cfg, input logic [2:0] strb,
      input logic [NB-1:0] hit, input logic [NB-1:0] flg, input logic sh, input logic ih);
    logic ps, rd, wr, dstr;
    logic [NB-1:0] e;
    ps = ~strb[2]; rd = ~strb[1]; wr = ~strb[0];
    for (int i = 0; i < NB; i++)
      e[i] = ~(hit[i] & (flg[i] ? rd : (ps | (cfg[1] & rd))));
    dstr = rd | wr | (cfg[0] & ps);
    return {e, ~(sh & dstr), ~(ih & dstr)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset readback", 32'(cfg_rdata), 32'h00);
    // R1: separate spaces at reset, PSEN to SRAM and RD to program block
    eprom_hit = 8'h01; sram_hit = 1'b1; psen_n = 1'b0; #1;
    check("R1 psen sram", 32'(sram_sel_n), 32'd1);
    check("R1 psen eprom", 32'(eprom_sel_n), 32'hFE);
    psen_n = 1'b1; rd_n = 1'b0; #1;
    check("R1 rd eprom", 32'(eprom_sel_n), 32'hFF);
    check("R1 rd sram", 32'(sram_sel_n), 32'd0);
    rd_n = 1'b1; eprom_hit = '0; sram_hit = 1'b0;

    cfg_write(1'b1, 1'b1, 8'hFF);
    check("R2 write all ones", 32'(cfg_rdata), 32'h83);
    cfg_write(1'b1, 1'b1, 8'h7C);
    check("R2 reserved bits ignored", 32'(cfg_rdata), 32'h00);
    cfg_write(1'b1, 1'b1, 8'h81);
    check("R2 write 81", 32'(cfg_rdata), 32'h81);
    cfg_write(1'b0, 1'b1, 8'h02);
    check("R3 cs low", 32'(cfg_rdata), 32'h81);
    cfg_write(1'b1, 1'b0, 8'h02);
    check("R3 we low", 32'(cfg_rdata), 32'h81);

    for (int m = 0; m < 8; m++) begin
      cur = {m[2], 5'b0, m[1:0]};
      cfg_write(1'b1, 1'b1, cur | 8'h7C);
      check("R2 mode readback", 32'(cfg_rdata), 32'(cur));
      for (int s = 0; s < 8; s++) begin
        for (int k = 0; k < 16; k++) begin
          logic [NB+1:0] ex;
          @(negedge clk);
          {psen_n, rd_n, wr_n} = 3'(s);
          eprom_hit = (k == 0) ? 8'hFF : 8'(k * 37 + 5);
          eprom_in_data = (k == 15) ? 8'h00 : 8'((k * 91) ^ 8'h5A);
          sram_hit = k[0] | (k == 0);
          io_hit = k[1] | (k == 0);
          #1;
          ex = expect_sel(cur, 3'(s), eprom_hit, eprom_in_data, sram_hit, io_hit);
          check("R4/R5/R6/R9/R10 eprom selects", 32'(eprom_sel_n), 32'(ex[NB+1:2]));
          check("R7/R8/R10 sram select", 32'(sram_sel_n), 32'(ex[1]));
          check("R7/R8/R10 io select", 32'(io_sel_n), 32'(ex[0]));
        end
      end
    end

    @(negedge clk);
    {psen_n, rd_n, wr_n} = 3'b111; eprom_hit = '1; sram_hit = 1'b1; io_hit = 1'b1; #1;
    check("R10 all strobes idle", 32'({eprom_sel_n, sram_sel_n, io_sel_n}), 32'h3FF);
    wr_n = 1'b0; #1;
    check("R9 wr never selects eprom", 32'(eprom_sel_n), 32'hFF);
    wr_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule